// File: doc/BRIEF.md
# Asynchronous Serial Frame Receiver

This block takes one NRZ serial line and turns each asynchronous frame on it into a parallel byte. It works from a one-cycle sample enable that pulses sixteen times per bit period. A falling edge on an idle line opens a frame. The low level must still be present at mid-bit, or the event is dropped as noise. Every later bit is resolved by a three-sample majority vote around the bit centre.

The frame is either ten bits long (start, eight data bits sent least significant bit first, stop) or eleven bits long, with a ninth parity/control bit placed before the stop bit. A select input picks the length. Any transition seen inside a data, ninth or stop bit that falls away from the centre moves the sixteen-step phase counter to line up with that transition. A sender whose clock is somewhat fast or slow is therefore still sampled near its bit centres. The parity policy is left to the logic that consumes the ninth bit.

Results appear on registered outputs together with a one-cycle valid strobe. They hold their values until the next frame completes.

Top module: `async_frame_rx`

## Requirements
- R1: While reset is high, and in the cycle after reset is released, `rx_valid`, `rx_frame_err`, `rx_bit9` and `rx_byte` are all 0.
- R2: In idle, a falling edge of the line seen on a sample tick starts a candidate frame, and that tick counts as phase 0. If the line is high at the phase-8 sample tick, the candidate is abandoned: no strobe is produced and the receiver waits for a new falling edge.
- R3: With `frame11` = 0, a frame is 1 start bit (0), 8 data bits with bit 0 sent first, and 1 stop bit. `rx_byte` then carries the eight data bits in their original weights.
- R4: With `frame11` = 1, a ninth bit follows the eighth data bit and comes before the stop bit, and `rx_bit9` reports its value. With `frame11` = 0, `rx_bit9` is 0 on every strobe.
- R5: Each bit value is the majority of the line samples taken at phases 7, 8 and 9 of that bit. A single-tick inversion at phase 8 therefore does not change the received value.
- R6: Inside a data, ninth or stop bit, a line transition at phase 1 to 6 reloads the phase so that the transition tick becomes phase 0 of the current bit. Inside a start, data or ninth bit, a transition at phase 10 to 15 ends the current bit and makes that tick phase 0 of the next bit. Frames whose bits last 15 or 17 ticks, and which have a transition at each bit boundary, are received correctly.
- R7: `rx_frame_err` is set to 1 when the stop bit is sampled low and to 0 when it is sampled high. It changes only in the cycle in which `rx_valid` is high.
- R8: `rx_valid` is high for exactly one clock cycle per completed frame. `rx_byte`, `rx_bit9` and `rx_frame_err` change only in that cycle.
- R9: The receiver advances only on cycles where `tick16` is high. A frame stretched by a gap in the ticks is still received correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick16 | input | 1 | Sample enable, sixteen pulses per bit period |
| frame11 | input | 1 | 1 selects 11-bit frames with a ninth bit, 0 selects 10-bit frames |
| rx_line | input | 1 | Serial input, idle high |
| rx_byte | output | 8 | Last received data byte |
| rx_bit9 | output | 1 | Last received ninth bit, 0 for 10-bit frames |
| rx_valid | output | 1 | One-cycle strobe when a frame completes |
| rx_frame_err | output | 1 | Stop bit of the last frame was sampled low |

## Verification
A phase counter that drifts or has been reloaded wrongly moves the sampling point toward a bit edge. With senders that run 15 or 17 ticks per bit, that shows within a frame or two as shifted or repeated bits in `rx_byte`, or as a spurious framing error. A bit counter or state that goes wrong shows in the frame where it happens: a strobe that comes early, comes late or is missing, a ninth bit on the wrong frame, or a strobe after a rejected glitch. The scoreboard catches all of these because every frame is compared in order.

// File: rtl/rx_pkg.sv
package rx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_NINTH,
    ST_STOP
  } rx_state_t;

  function automatic logic maj3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

endpackage

// File: rtl/rx_line_sync.sv
module rx_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= 1'b1;
          else     chain[0] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[g] <= 1'b1;
          else     chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/rx_edge_tracker.sv
module rx_edge_tracker (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic line,
  output logic edge_seen,
  output logic fall_seen
);
  logic line_prev;

  always_ff @(posedge clk) begin
    if (rst)       line_prev <= 1'b1;
    else if (tick) line_prev <= line;
  end

  assign edge_seen = tick & (line ^ line_prev);
  assign fall_seen = edge_seen & ~line;
endmodule

// File: rtl/rx_vote3.sv
module rx_vote3 import rx_pkg::*; #(
  parameter int OVERSAMPLE = 16,
  localparam int PH_W = $clog2(OVERSAMPLE)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            tick,
  input  logic [PH_W-1:0] phase,
  input  logic            line,
  output logic            voted
);
  localparam logic [PH_W-1:0] PH_A = PH_W'(OVERSAMPLE / 2 - 1);
  localparam logic [PH_W-1:0] PH_B = PH_W'(OVERSAMPLE / 2);

  logic samp_a, samp_b;

  always_ff @(posedge clk) begin
    if (rst) begin
      samp_a <= 1'b1;
      samp_b <= 1'b1;
    end else if (tick) begin
      if (phase == PH_A) samp_a <= line;
      if (phase == PH_B) samp_b <= line;
    end
  end

  // third sample is the live line at the decision phase
  assign voted = maj3(samp_a, samp_b, line);
endmodule

// File: rtl/rx_frame_ctl.sv
module rx_frame_ctl import rx_pkg::*; #(
  parameter int DATA_BITS  = 8,
  parameter int OVERSAMPLE = 16,
  localparam int PH_W  = $clog2(OVERSAMPLE),
  localparam int CNT_W = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 tick,
  input  logic                 frame11,
  input  logic                 line,
  input  logic                 edge_seen,
  input  logic                 fall_seen,
  input  logic                 voted,
  output logic [PH_W-1:0]      phase,
  output logic [DATA_BITS-1:0] byte_o,
  output logic                 bit9_o,
  output logic                 valid_o,
  output logic                 err_o
);
  localparam int MID = OVERSAMPLE / 2;
  localparam logic [PH_W-1:0]  PH_ONE   = PH_W'(1);
  localparam logic [PH_W-1:0]  PH_MID   = PH_W'(MID);
  localparam logic [PH_W-1:0]  PH_SAMP  = PH_W'(MID + 1);
  localparam logic [PH_W-1:0]  PH_LATE  = PH_W'(MID - 2);
  localparam logic [PH_W-1:0]  PH_EARLY = PH_W'(MID + 2);
  localparam logic [PH_W-1:0]  PH_LAST  = PH_W'(OVERSAMPLE - 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_BITS - 1);

  rx_state_t            state, state_n;
  logic [PH_W-1:0]      phase_n;
  logic [CNT_W-1:0]     cnt, cnt_n;
  logic [DATA_BITS-1:0] shreg, shreg_n;
  logic                 ninth, ninth_n;
  logic                 done, step;
  logic                 late_win, early_win;

  assign late_win  = (phase != '0) && (phase <= PH_LATE);
  assign early_win = (phase >= PH_EARLY);

  always_comb begin
    state_n = state;
    phase_n = phase;
    cnt_n   = cnt;
    shreg_n = shreg;
    ninth_n = ninth;
    done    = 1'b0;
    step    = 1'b0;
    if (tick) begin
      case (state)
        ST_IDLE: begin
          if (fall_seen) begin
            state_n = ST_START;
            phase_n = '0;
          end
        end
        ST_START: begin
          if (edge_seen && early_win) begin
            state_n = ST_DATA;
            cnt_n   = '0;
            phase_n = PH_ONE;
          end else if (phase == PH_MID && line) begin
            state_n = ST_IDLE;
            phase_n = '0;
          end else if (phase == PH_LAST) begin
            state_n = ST_DATA;
            cnt_n   = '0;
            phase_n = '0;
          end else begin
            phase_n = phase + PH_ONE;
          end
        end
        default: begin
          if (state == ST_STOP && phase == PH_SAMP) begin
            done    = 1'b1;
            state_n = ST_IDLE;
            phase_n = '0;
          end else begin
            if (phase == PH_SAMP) begin
              if (state == ST_DATA)       shreg_n = {voted, shreg[DATA_BITS-1:1]};
              else if (state == ST_NINTH) ninth_n = voted;
            end
            if (edge_seen && late_win) begin
              phase_n = PH_ONE;
            end else if (edge_seen && early_win && state != ST_STOP) begin
              phase_n = PH_ONE;
              step    = 1'b1;
            end else if (phase == PH_LAST) begin
              phase_n = '0;
              step    = 1'b1;
            end else begin
              phase_n = phase + PH_ONE;
            end
            if (step) begin
              if (state == ST_DATA) begin
                if (cnt == LAST_BIT) state_n = frame11 ? ST_NINTH : ST_STOP;
                else                 cnt_n   = cnt + CNT_W'(1);
              end else if (state == ST_NINTH) begin
                state_n = ST_STOP;
              end
            end
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      phase <= '0;
      cnt   <= '0;
      shreg <= '0;
      ninth <= 1'b0;
    end else begin
      state <= state_n;
      phase <= phase_n;
      cnt   <= cnt_n;
      shreg <= shreg_n;
      ninth <= ninth_n;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_o <= 1'b0;
      byte_o  <= '0;
      bit9_o  <= 1'b0;
      err_o   <= 1'b0;
    end else begin
      valid_o <= done;
      if (done) begin
        byte_o <= shreg;
        bit9_o <= frame11 & ninth;
        err_o  <= ~voted;
      end
    end
  end

  // R9: nothing moves between ticks
  assert_hold_without_tick_R9: assert property (@(posedge clk) disable iff (rst)
    !tick |=> ($stable(phase) && $stable(state)));

  // R2: a high line at mid-bit drops the start candidate
  assert_glitch_dropped_R2: assert property (@(posedge clk) disable iff (rst)
    (state == ST_START && tick && phase == PH_MID && line && !edge_seen) |=> state == ST_IDLE);

  // R6: a late transition inside a data bit realigns the phase
  assert_late_edge_realigns_R6: assert property (@(posedge clk) disable iff (rst)
    (state == ST_DATA && edge_seen && late_win) |=> (phase == PH_ONE && state == ST_DATA));
endmodule

// File: rtl/async_frame_rx.sv
module async_frame_rx #(
  parameter int DATA_BITS   = 8,
  parameter int OVERSAMPLE  = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 tick16,
  input  logic                 frame11,
  input  logic                 rx_line,
  output logic [DATA_BITS-1:0] rx_byte,
  output logic                 rx_bit9,
  output logic                 rx_valid,
  output logic                 rx_frame_err
);
  localparam int PH_W = $clog2(OVERSAMPLE);

  logic            line_s;
  logic            edge_seen, fall_seen, voted;
  logic [PH_W-1:0] phase;

  rx_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .din(rx_line), .dout(line_s)
  );

  rx_edge_tracker u_edge (
    .clk(clk), .rst(rst), .tick(tick16), .line(line_s),
    .edge_seen(edge_seen), .fall_seen(fall_seen)
  );

  rx_vote3 #(.OVERSAMPLE(OVERSAMPLE)) u_vote (
    .clk(clk), .rst(rst), .tick(tick16), .phase(phase), .line(line_s), .voted(voted)
  );

  rx_frame_ctl #(.DATA_BITS(DATA_BITS), .OVERSAMPLE(OVERSAMPLE)) u_ctl (
    .clk(clk), .rst(rst), .tick(tick16), .frame11(frame11), .line(line_s),
    .edge_seen(edge_seen), .fall_seen(fall_seen), .voted(voted),
    .phase(phase), .byte_o(rx_byte), .bit9_o(rx_bit9),
    .valid_o(rx_valid), .err_o(rx_frame_err)
  );

  // R8: strobe lasts one cycle
  assert_valid_single_R8: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid);

  // R8: byte only moves with the strobe
  assert_byte_held_R8: assert property (@(posedge clk) disable iff (rst)
    !$stable(rx_byte) |-> rx_valid);

  // R7: error flag only moves with the strobe
  assert_err_with_valid_R7: assert property (@(posedge clk) disable iff (rst)
    !$stable(rx_frame_err) |-> rx_valid);

  // R4: short frames report a zero ninth bit
  assert_bit9_zero_short_R4: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && !$past(frame11)) |-> !rx_bit9);
endmodule

// File: tb/async_frame_rx_test.sv
module async_frame_rx_test;
  localparam int CLK_PERIOD = 10;
  localparam int TICK_DIV   = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick16 = 1'b0;
  logic       frame11 = 1'b0;
  logic       rx_line = 1'b1;
  logic [7:0] rx_byte;
  logic       rx_bit9, rx_valid, rx_frame_err;

  int checks = 0;
  int fails  = 0;
  int div    = 0;
  logic tick_run = 1'b1;
  logic prev_valid = 1'b0;
  logic finished = 1'b0;

  logic [9:0] exp_q[$];
  string      tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  async_frame_rx uut (
    .clk(clk), .rst(rst), .tick16(tick16), .frame11(frame11), .rx_line(rx_line),
    .rx_byte(rx_byte), .rx_bit9(rx_bit9), .rx_valid(rx_valid), .rx_frame_err(rx_frame_err)
  );

  always @(posedge clk) begin
    if (rst) begin
      div    <= 0;
      tick16 <= 1'b0;
    end else if (!tick_run) begin
      tick16 <= 1'b0;
    end else begin
      div    <= (div == TICK_DIV - 1) ? 0 : div + 1;
      tick16 <= (div == TICK_DIV - 1);
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic wait_tick();
    @(negedge clk);
    while (!tick16) @(negedge clk);
  endtask

  task automatic hold(input logic v, input int n);
    rx_line = v;
    repeat (n) wait_tick();
  endtask

  task automatic send_frame(input logic [7:0] d, input logic b9, input logic stop,
                            input int bt, input logic spike, input logic pause,
                            input string tag);
    exp_q.push_back({d, frame11 & b9, ~stop});
    tag_q.push_back(tag);
    hold(1'b0, bt);
    for (int i = 0; i < 8; i++) begin
      if (spike) begin
        hold(d[i], 8);
        hold(~d[i], 1);
        hold(d[i], bt - 9);
      end else if (pause && i == 3) begin
        hold(d[i], 5);
        tick_run = 1'b0;
        repeat (40) @(negedge clk);
        tick_run = 1'b1;
        hold(d[i], bt - 5);
      end else begin
        hold(d[i], bt);
      end
    end
    if (frame11) hold(b9, bt);
    hold(stop, bt);
    hold(1'b1, 20);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst) begin
      if (rx_valid && prev_valid) check("R8 strobe width", 32'd2, 32'd1);
      if (rx_valid) begin
        if (exp_q.size() == 0) begin
          check("R2 unexpected strobe", 32'd1, 32'd0);
        end else begin
          logic [9:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check({t, " byte"}, 32'(rx_byte), 32'(e[9:2]));
          check("R4 ninth bit", 32'(rx_bit9), 32'(e[1]));
          check("R7 frame error", 32'(rx_frame_err), 32'(e[0]));
        end
      end
      prev_valid = rx_valid;
    end
  end

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=done");
      report();
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    check("R1 valid in reset", 32'(rx_valid), 32'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 valid after reset", 32'(rx_valid), 32'd0);
    check("R1 byte after reset", 32'(rx_byte), 32'd0);
    check("R1 err after reset", 32'(rx_frame_err), 32'd0);
    check("R1 bit9 after reset", 32'(rx_bit9), 32'd0);
    wait_tick();
    hold(1'b1, 20);

    // R3 short frames, various patterns
    frame11 = 1'b0;
    send_frame(8'hA5, 1'b0, 1'b1, 16, 1'b0, 1'b0, "R3");
    send_frame(8'h00, 1'b0, 1'b1, 16, 1'b0, 1'b0, "R3");
    send_frame(8'hFF, 1'b0, 1'b1, 16, 1'b0, 1'b0, "R3");
    send_frame(8'h3C, 1'b0, 1'b1, 16, 1'b0, 1'b0, "R3");

    // R4 long frames with ninth bit
    frame11 = 1'b1;
    send_frame(8'h81, 1'b1, 1'b1, 16, 1'b0, 1'b0, "R4");
    send_frame(8'h7E, 1'b0, 1'b1, 16, 1'b0, 1'b0, "R4");
    send_frame(8'h01, 1'b1, 1'b1, 16, 1'b0, 1'b0, "R4");
    frame11 = 1'b0;
    send_frame(8'h96, 1'b0, 1'b1, 16, 1'b0, 1'b0, "R4 short after long");

    // R7 framing errors
    send_frame(8'h5A, 1'b0, 1'b0, 16, 1'b0, 1'b0, "R7");
    frame11 = 1'b1;
    send_frame(8'hC3, 1'b1, 1'b0, 16, 1'b0, 1'b0, "R7");
    send_frame(8'h24, 1'b1, 1'b1, 16, 1'b0, 1'b0, "R7 clear");
    frame11 = 1'b0;

    // R2 glitches on idle line: 4 and 8 ticks low
    hold(1'b0, 4);
    hold(1'b1, 30);
    hold(1'b0, 8);
    hold(1'b1, 30);
    check("R2 no strobe after glitch", 32'(exp_q.size()), 32'd0);
    send_frame(8'h69, 1'b0, 1'b1, 16, 1'b0, 1'b0, "R2 after glitch");

    // R5 single-tick spikes at mid-bit
    send_frame(8'hB2, 1'b0, 1'b1, 16, 1'b1, 1'b0, "R5");
    frame11 = 1'b1;
    send_frame(8'h4D, 1'b1, 1'b1, 16, 1'b1, 1'b0, "R5");
    frame11 = 1'b0;

    // R6 sender clock slow and fast
    send_frame(8'h55, 1'b0, 1'b1, 17, 1'b0, 1'b0, "R6 slow");
    send_frame(8'hAA, 1'b0, 1'b1, 17, 1'b0, 1'b0, "R6 slow");
    send_frame(8'h55, 1'b0, 1'b1, 15, 1'b0, 1'b0, "R6 fast");
    send_frame(8'hAA, 1'b0, 1'b1, 15, 1'b0, 1'b0, "R6 fast");

    // R9 tick gap inside a frame
    send_frame(8'hE7, 1'b0, 1'b1, 16, 1'b0, 1'b1, "R9");

    hold(1'b1, 32);
    check("R8 all frames strobed", 32'(exp_q.size()), 32'd0);
    finished = 1'b1;
    report();
  end
endmodule